// File: doc/BRIEF.md
# Asynchronous 64K x 1 SRAM Cycle Controller

This block lets a synchronous host read and write single bits in an asynchronous static RAM that holds 64K one-bit words. The host presents a request with a valid/ready handshake, a write flag, a 16-bit address and one write-data bit. Read results come back on a one-bit data output, marked by a one-cycle read-valid strobe.

On the memory side the controller drives the address lines, an active-low chip enable, an active-low write enable and the data-in pin. It samples the data-out pin. Every memory-side output comes from a register, so none of them can glitch. All timing figures are set as parameters in nanoseconds. Each one becomes a cycle count by rounding up against the clock period, with a floor of one cycle.

Writes are controlled by write enable. Chip enable falls first, and the address and data are settled one cycle before write enable falls. Write enable rises before chip enable, and the address and data stay frozen while both strobes are low. After every cycle, chip enable is held high for a recovery gap so that the memory output can reach high impedance before the next access.

Top module: `sram64k_ctrl`

## Requirements
- R1: After reset, req_ready is 1, mem_ce_n is 1, mem_we_n is 1 and rd_valid is 0.
- R2: A read holds mem_ce_n low with mem_we_n high. It then returns on rd_data the bit most recently written to that address, or 0 if the address was never written.
- R3: mem_we_n is low only while mem_ce_n is low. A write stores req_wdata at req_addr.
- R4: Each low pulse of mem_we_n lasts at least ceil(T_WP_NS/CLK_NS) cycles (3 at the defaults). When mem_we_n rises, mem_ce_n is still low.
- R5: While mem_ce_n and mem_we_n are both low, mem_addr and mem_din do not change.
- R6: Between the rise of mem_ce_n and its next fall there are at least max(ceil(T_HZ_NS/CLK_NS), ceil(T_WR_NS/CLK_NS)) cycles with mem_ce_n high (2 at the defaults).
- R7: rd_valid is a pulse exactly one cycle wide, given once per read.
- R8: A request is taken only when req_valid and req_ready are both 1. While req_valid is 0, mem_ce_n stays high. req_ready stays 0 from acceptance until the recovery gap ends, and in particular it is 0 whenever mem_ce_n is low.
- R9: Every read and every write keeps mem_ce_n low for at least ceil(max(T_CYC_NS,T_ACC_NS)/CLK_NS) cycles (5 at the defaults). Read data is sampled only on the last edge of that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 1 | Bit to write |
| rd_data | output | 1 | Bit read back |
| rd_valid | output | 1 | One-cycle strobe marking rd_data |
| mem_addr | output | 16 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_din | output | 1 | Data driven into the memory |
| mem_dout | input | 1 | Data read from the memory |

## Verification
The hardest situation to reach from the ports is one where an early or late sample of mem_dout would still return the right bit by chance. A lenient memory model would never show the difference. The bench's memory model therefore drives the inverse of the stored bit until chip enable has been low for the full access window, so a read that samples too early returns a wrong value.

A second difficult case is host signals that change while a write is in flight. After each request is accepted, the bench scrambles the host address, so any leak from the host bus onto the frozen memory address shows up. Random reads and writes to a narrow address range and to both address extremes make write-then-read collisions frequent.

// File: rtl/sram64k_ctrl.sv
module sram64k_ctrl #(
  parameter int CLK_NS    = 10,
  parameter int T_CYC_NS  = 50,
  parameter int T_ACC_NS  = 50,
  parameter int T_WP_NS   = 30,
  parameter int T_HZ_NS   = 15,
  parameter int T_WR_NS   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic        req_wdata,
  output logic        rd_data,
  output logic        rd_valid,
  output logic [15:0] mem_addr,
  output logic        mem_ce_n,
  output logic        mem_we_n,
  output logic        mem_din,
  input  logic        mem_dout
);

  function automatic int to_cyc(int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC  = to_cyc(imax(T_CYC_NS, T_ACC_NS));
  localparam int WP_CYC  = imax(to_cyc(T_WP_NS), imax(RD_CYC - 2, 1));
  localparam int GAP_CYC = imax(to_cyc(T_HZ_NS), to_cyc(T_WR_NS));
  localparam int CNT_W   = $clog2(imax(imax(RD_CYC, WP_CYC), GAP_CYC) + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WSET, S_WSTB, S_WEND, S_GAP} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;

  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      mem_addr <= '0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_din  <= 1'b0;
      rd_data  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          if (req_write) begin
            mem_din <= req_wdata;
            state   <= S_WSET;
          end else begin
            cnt   <= CNT_W'(RD_CYC - 1);
            state <= S_READ;
          end
        end
        S_READ: if (cnt == '0) begin
          rd_data  <= mem_dout;
          rd_valid <= 1'b1;
          mem_ce_n <= 1'b1;
          cnt      <= CNT_W'(GAP_CYC - 1);
          state    <= S_GAP;
        end else cnt <= cnt - 1'b1;
        S_WSET: begin
          mem_we_n <= 1'b0;
          cnt      <= CNT_W'(WP_CYC - 1);
          state    <= S_WSTB;
        end
        S_WSTB: if (cnt == '0) begin
          mem_we_n <= 1'b1;
          state    <= S_WEND;
        end else cnt <= cnt - 1'b1;
        S_WEND: begin
          mem_ce_n <= 1'b1;
          cnt      <= CNT_W'(GAP_CYC - 1);
          state    <= S_GAP;
        end
        S_GAP: if (cnt == '0) state <= S_IDLE;
               else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram64k_ctrl_chk.sv
module sram64k_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rd_valid,
  input logic [15:0] mem_addr,
  input logic        mem_ce_n,
  input logic        mem_we_n,
  input logic        mem_din
);

  p_we_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  p_ce_outlasts_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);

  p_addr_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_we_n && $past(!mem_ce_n && !mem_we_n)) |->
      ($stable(mem_addr) && $stable(mem_din)));

  p_gap_after_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |=> mem_ce_n);

  p_rdvalid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

endmodule

bind sram64k_ctrl sram64k_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_din(mem_din)
);

// File: tb/sram64k_ctrl_bench.sv
module sram64k_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RD_MIN  = 5;
  localparam int WP_MIN  = 3;
  localparam int GAP_MIN = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_wdata = 0;
  logic [15:0] req_addr = '0;
  logic req_ready, rd_data, rd_valid;
  logic [15:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_din;
  logic mem_dout = 0;

  int tests = 0, fails = 0, cycles = 0;
  bit model   [int unsigned];
  bit exp_mem [int unsigned];

  sram64k_ctrl u_sram64k_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_din(mem_din), .mem_dout(mem_dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit rd_model(int unsigned a);
    return model.exists(a) ? model[a] : 1'b0;
  endfunction

  function automatic bit rd_exp(int unsigned a);
    return exp_mem.exists(a) ? exp_mem[a] : 1'b0;
  endfunction

  // memory model and protocol monitor
  bit prev_ce = 1, prev_we = 1, prev_rdv = 0, prev_din = 0;
  logic [15:0] prev_addr = '0;
  int ce_lo = 0, we_lo = 0, gap = 99;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (!mem_ce_n) begin
        ce_lo++;
        if (prev_ce) begin
          check(gap >= GAP_MIN, "R6", gap, GAP_MIN);
          gap = 0;
        end
        check(!req_ready, "R8", req_ready, 0);
      end else begin
        if (!prev_ce) begin
          check(ce_lo >= RD_MIN, "R9", ce_lo, RD_MIN);
          ce_lo = 0;
        end
        gap++;
      end
      if (!mem_we_n) begin
        we_lo++;
        check(!mem_ce_n, "R3", mem_ce_n, 0);
      end else if (!prev_we) begin
        check(we_lo >= WP_MIN, "R4", we_lo, WP_MIN);
        check(!mem_ce_n, "R4", mem_ce_n, 0);
        model[prev_addr] = prev_din;
        we_lo = 0;
      end
      if (!mem_ce_n && !mem_we_n && !prev_ce && !prev_we) begin
        check(mem_addr == prev_addr, "R5", mem_addr, prev_addr);
        check(mem_din == prev_din, "R5", mem_din, prev_din);
      end
      if (rd_valid && prev_rdv) check(0, "R7", 2, 1);
      if (!mem_ce_n && mem_we_n)
        mem_dout <= (ce_lo >= RD_MIN) ? rd_model(mem_addr) : ~rd_model(mem_addr);
      else
        mem_dout <= 1'b0;
    end
    prev_ce = mem_ce_n; prev_we = mem_we_n; prev_rdv = rd_valid;
    prev_addr = mem_addr; prev_din = mem_din;
  end

  task automatic do_op(bit w, logic [15:0] a, bit d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_addr = 16'($urandom); req_wdata = ~d;
    check(!req_ready, "R8", req_ready, 0);
    if (w) exp_mem[a] = d;
    else begin
      int n = 0;
      while (!rd_valid && n < 100) begin @(negedge clk); n++; end
      check(rd_valid == 1'b1, "R7", rd_valid, 1);
      check(rd_data == rd_exp(a), "R2", rd_data, rd_exp(a));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(req_ready == 1, "R1", req_ready, 1);
    check(mem_ce_n == 1, "R1", mem_ce_n, 1);
    check(mem_we_n == 1, "R1", mem_we_n, 1);
    check(rd_valid == 0, "R1", rd_valid, 0);
    rst_n = 1;
    // R8: junk on the host bus without valid starts nothing
    req_write = 1; req_addr = 16'h1234; req_wdata = 1;
    repeat (6) begin
      @(negedge clk);
      check(mem_ce_n == 1, "R8", mem_ce_n, 1);
    end
    // directed corners: both address extremes, unwritten read, overwrite
    do_op(0, 16'h0042, 0);
    do_op(1, 16'h0000, 1);
    do_op(1, 16'hFFFF, 1);
    do_op(0, 16'h0000, 0);
    do_op(0, 16'hFFFF, 0);
    do_op(1, 16'hFFFF, 0);
    do_op(0, 16'hFFFF, 0);
    do_op(1, 16'h8001, 1);
    do_op(0, 16'h8001, 0);
    // random mix on a narrow window to force collisions
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = (i % 5 == 0) ? 16'($urandom) : {12'hA5C, 4'($urandom)};
      do_op(1'($urandom), a, 1'($urandom));
    end
    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    check(0, "watchdog", cycles, 150000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule